// File: doc/BRIEF.md
# Quadrature Position Decoder

This block turns the two phase signals and the index pulse of a rotary encoder into a 16-bit position count and a signed rotation count. Each input first passes a synchronizer. A sampler then reads it on a programmable tick, and an optional debounce filter removes short glitches. A four-edge decoder then counts one step for every legal phase change and flags changes where both phases move at once.

Control comes through plain write-enable ports. They set the enable, the counter clears, the rotation counting mode, the debounce settings, the tick divider and the interrupt mask. The counter clears only act while the block is disabled. Sticky status flags record overflow, underflow, index events and illegal transitions. The flags are cleared by writing 1. A single interrupt line ORs the flags that are unmasked.

Top module: `quad_decoder`

## Requirements
- R1: After reset the position count, rotation count, status and interrupt are all zero.
- R2: The phase state {A,B} runs 00, 01, 11, 10 and back to 00 in the up direction. Each step forward adds 1 to the position and each step backward subtracts 1. The last legal step sets the direction.
- R3: A change of both phases in one filtered update leaves the position unchanged and sets status bit 3.
- R4: Stepping up from 0xFFFF gives 0 and sets status bit 0. Stepping down from 0 gives 0xFFFF and sets status bit 1.
- R5: A rising edge of the filtered index input while enabled sets status bit 2. In rotation mode 0 it also adds +1 to the rotation count when the current direction is up, or -1 when it is down.
- R6: In rotation mode 1 the rotation count adds +1 on each position overflow and -1 on each underflow. Index events do not change it.
- R7: While the enable register is 0, neither count changes from phase or index activity, and the status reads zero.
- R8: A position clear request sets the position to 0 only if the enable register was 0 when the request was written. Otherwise the request has no effect.
- R9: A rotation clear request sets the rotation count to 0 under the same rule as R8.
- R10: A full clear request returns the position, rotation, status and direction to their reset values, under the same rule as R8.
- R11: The sampling tick fires once every (cfg_div + 1) clock cycles.
- R12: With debounce on, a filtered input changes only after the new level has been sampled for max(cfg_dbn_time, 1) ticks in a row. Shorter pulses are dropped. With debounce off, every tick passes the sample through.
- R13: Writing 1 to a bit of sts_clr_mask clears that status bit, but a new event in the same cycle wins over the clear. irq is high when any status bit is set whose ctl_irq_mask bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the divider and debounce time |
| cfg_div | input | 5 | Sampling tick divider |
| cfg_dbn_time | input | 11 | Debounce length in ticks |
| ctl_we | input | 1 | Write strobe for the control fields |
| ctl_enable | input | 1 | Decoder enable |
| ctl_pos_clr | input | 1 | Position clear request |
| ctl_rot_clr | input | 1 | Rotation clear request |
| ctl_rot_mode | input | 1 | 0: count index events, 1: count wraps |
| ctl_full_clr | input | 1 | Full clear request |
| ctl_dbn_en | input | 1 | Debounce enable |
| ctl_irq_mask | input | 4 | Interrupt enable per status bit |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_mask | input | 4 | Status bits to clear |
| in_a | input | 1 | Encoder phase A |
| in_b | input | 1 | Encoder phase B |
| in_idx | input | 1 | Encoder index |
| pos_count | output | 16 | Position count |
| rot_count | output | 16 | Rotation count, two's complement |
| status | output | 4 | Sticky flags: 0 overflow, 1 underflow, 2 index, 3 illegal |
| irq | output | 1 | Masked OR of the status flags |

## Verification
A wrong phase history or direction shows up as a position count off by one step, or as a spurious illegal flag, within about four clocks of the offending input change when the tick runs every cycle. A debounce or divider counter that is off by one only shows when a pulse sits close to the acceptance window. For that reason glitches are sized to fall just short of the window and holds to pass it well, both at divider 0 and at divider 9. A clear gate that ignores the enable appears at once as a count that drops to zero while the block is enabled.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
   localparam int NFLAG   = 4;
   localparam int FLG_OVF = 0;
   localparam int FLG_UNF = 1;
   localparam int FLG_IDX = 2;
   localparam int FLG_ERR = 3;

   // ordinal of a phase state along the up direction 00,01,11,10
   function automatic logic [1:0] phase_ord(input logic [1:0] ab);
      case (ab)
         2'b00:   return 2'd0;
         2'b01:   return 2'd1;
         2'b11:   return 2'd2;
         default: return 2'd3;
      endcase
   endfunction
endpackage

// File: rtl/qdec_tick.sv
module qdec_tick #(
   parameter int DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt_q;

   assign tick_o = (cnt_q >= div_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + DIV_W'(1);
   end

   // R11: with a nonzero divider two ticks never come back to back
   a_r11_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/qdec_filt.sv
module qdec_filt #(
   parameter int SYNC_STAGES = 2,
   parameter int TM_W        = 11
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_i,
   input  logic            dbn_en_i,
   input  logic [TM_W-1:0] dbn_tm_i,
   input  logic            raw_i,
   output logic            out_o
);
   logic            smp;
   logic [TM_W-1:0] run_q;
   logic [TM_W-1:0] thr;

   generate
      if (SYNC_STAGES > 0) begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else begin
               sync_q[0] <= raw_i;
               for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
            end
         end
         assign smp = sync_q[SYNC_STAGES-1];
      end else begin : g_nosync
         assign smp = raw_i;
      end
   endgenerate

   assign thr = (dbn_tm_i == '0) ? TM_W'(1) : dbn_tm_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_o <= 1'b0;
         run_q <= '0;
      end else if (tick_i) begin
         if (!dbn_en_i) begin
            out_o <= smp;
            run_q <= '0;
         end else if (smp == out_o) begin
            run_q <= '0;
         end else if (({1'b0, run_q} + (TM_W+1)'(1)) >= {1'b0, thr}) begin
            out_o <= smp;
            run_q <= '0;
         end else begin
            run_q <= run_q + TM_W'(1);
         end
      end
   end

   // R12: the filtered level only moves on a sampling tick
   a_r12_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(out_o));
endmodule

// File: rtl/qdec_step.sv
module qdec_step (
   input  logic [1:0] prev_i,
   input  logic [1:0] now_i,
   output logic       up_o,
   output logic       dn_o,
   output logic       err_o
);
   import qdec_pkg::*;
   logic [1:0] diff;

   always_comb begin
      diff  = phase_ord(now_i) - phase_ord(prev_i);
      up_o  = (diff == 2'd1);
      dn_o  = (diff == 2'd3);
      err_o = (diff == 2'd2);
   end
endmodule

// File: rtl/quad_decoder.sv
module quad_decoder #(
   parameter int POS_W       = 16,
   parameter int ROT_W       = 16,
   parameter int DIV_W       = 5,
   parameter int TM_W        = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic [DIV_W-1:0]           cfg_div,
   input  logic [TM_W-1:0]            cfg_dbn_time,
   input  logic                       ctl_we,
   input  logic                       ctl_enable,
   input  logic                       ctl_pos_clr,
   input  logic                       ctl_rot_clr,
   input  logic                       ctl_rot_mode,
   input  logic                       ctl_full_clr,
   input  logic                       ctl_dbn_en,
   input  logic [qdec_pkg::NFLAG-1:0] ctl_irq_mask,
   input  logic                       sts_clr_we,
   input  logic [qdec_pkg::NFLAG-1:0] sts_clr_mask,
   input  logic                       in_a,
   input  logic                       in_b,
   input  logic                       in_idx,
   output logic [POS_W-1:0]           pos_count,
   output logic [ROT_W-1:0]           rot_count,
   output logic [qdec_pkg::NFLAG-1:0] status,
   output logic                       irq
);
   import qdec_pkg::*;

   localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
   localparam int NLINE = 3;

   generate
      if (POS_W < 2) begin : g_chk_pos
         $error("POS_W must be at least 2");
      end
      if (ROT_W < 2) begin : g_chk_rot
         $error("ROT_W must be at least 2");
      end
      if (DIV_W < 1 || TM_W < 1) begin : g_chk_cfg
         $error("DIV_W and TM_W must be at least 1");
      end
   endgenerate

   // configuration and control registers
   logic [DIV_W-1:0] div_q;
   logic [TM_W-1:0]  dbn_tm_q;
   logic             en_q, mode_q, dbn_en_q;
   logic [NFLAG-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q    <= '0;
         dbn_tm_q <= '0;
         en_q     <= 1'b0;
         mode_q   <= 1'b0;
         dbn_en_q <= 1'b0;
         mask_q   <= '0;
      end else begin
         if (cfg_we) begin
            div_q    <= cfg_div;
            dbn_tm_q <= cfg_dbn_time;
         end
         if (ctl_we) begin
            en_q     <= ctl_enable;
            mode_q   <= ctl_rot_mode;
            dbn_en_q <= ctl_dbn_en;
            mask_q   <= ctl_irq_mask;
         end
      end
   end

   // clear requests pass only while the decoder is disabled
   logic pos_clr_ok, rot_clr_ok, full_clr_ok;
   assign pos_clr_ok  = ctl_we && ctl_pos_clr  && !en_q;
   assign rot_clr_ok  = ctl_we && ctl_rot_clr  && !en_q;
   assign full_clr_ok = ctl_we && ctl_full_clr && !en_q;

   // input conditioning
   logic             tick;
   logic [NLINE-1:0] raw_lines, filt_lines;
   assign raw_lines = {in_idx, in_a, in_b};

   qdec_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .div_i(div_q), .tick_o(tick)
   );

   generate
      for (genvar g = 0; g < NLINE; g++) begin : g_line
         qdec_filt #(.SYNC_STAGES(SYNC_STAGES), .TM_W(TM_W)) u_filt (
            .clk(clk), .rst_n(rst_n), .tick_i(tick), .dbn_en_i(dbn_en_q),
            .dbn_tm_i(dbn_tm_q), .raw_i(raw_lines[g]), .out_o(filt_lines[g])
         );
      end
   endgenerate

   // step decode
   logic [1:0] ab_now, ab_prev_q;
   logic       idx_prev_q, idx_rise;
   logic       step_up, step_dn, step_err;
   assign ab_now   = filt_lines[1:0];
   assign idx_rise = filt_lines[2] && !idx_prev_q;

   qdec_step u_step (
      .prev_i(ab_prev_q), .now_i(ab_now),
      .up_o(step_up), .dn_o(step_dn), .err_o(step_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ab_prev_q  <= 2'b00;
         idx_prev_q <= 1'b0;
      end else begin
         ab_prev_q  <= ab_now;
         idx_prev_q <= filt_lines[2];
      end
   end

   // counters
   logic [POS_W-1:0] pos_q;
   logic [ROT_W-1:0] rot_q;
   logic             dir_q;
   logic             wrap_up, wrap_dn;
   assign wrap_up = en_q && step_up && (pos_q == POS_MAX);
   assign wrap_dn = en_q && step_dn && (pos_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         dir_q <= 1'b1;
      end else if (full_clr_ok) begin
         pos_q <= '0;
         dir_q <= 1'b1;
      end else if (pos_clr_ok) begin
         pos_q <= '0;
      end else if (en_q && step_up) begin
         pos_q <= pos_q + POS_W'(1);
         dir_q <= 1'b1;
      end else if (en_q && step_dn) begin
         pos_q <= pos_q - POS_W'(1);
         dir_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     rot_q <= '0;
      else if (full_clr_ok || rot_clr_ok) rot_q <= '0;
      else if (en_q) begin
         if (!mode_q) begin
            if (idx_rise) rot_q <= dir_q ? rot_q + ROT_W'(1) : rot_q - ROT_W'(1);
         end else begin
            if (wrap_up)      rot_q <= rot_q + ROT_W'(1);
            else if (wrap_dn) rot_q <= rot_q - ROT_W'(1);
         end
      end
   end

   // sticky status
   logic [NFLAG-1:0] sts_q, sts_set, sts_clr;
   always_comb begin
      sts_set          = '0;
      sts_set[FLG_OVF] = wrap_up;
      sts_set[FLG_UNF] = wrap_dn;
      sts_set[FLG_IDX] = en_q && idx_rise;
      sts_set[FLG_ERR] = en_q && step_err;
      sts_clr          = sts_clr_we ? sts_clr_mask : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   sts_q <= '0;
      else if (full_clr_ok || !en_q) sts_q <= '0;
      else                          sts_q <= (sts_q & ~sts_clr) | sts_set;
   end

   assign pos_count = pos_q;
   assign rot_count = rot_q;
   assign status    = sts_q;
   assign irq       = |(sts_q & mask_q);

   // R7: disabled means no flags on the following cycle
   a_r7_disabled_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> (sts_q == '0));
   // R7: disabled and no control write leaves both counts still
   a_r7_disabled_holds_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !ctl_we) |=> ($stable(pos_q) && $stable(rot_q)));
   // R8: while enabled the position moves by at most one step, so no clear lands
   a_r8_enabled_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> (pos_q == $past(pos_q) || pos_q == $past(pos_q) + POS_W'(1)
                || pos_q == $past(pos_q) - POS_W'(1)));
   // R3: an illegal transition leaves the position and raises the error flag
   a_r3_illegal_no_count: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && step_err) |=> ($stable(pos_q) && sts_q[FLG_ERR]));
   // R6: wrap counting mode ignores index events
   a_r6_mode1_index_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && mode_q && !ctl_we && !step_up && !step_dn) |=> $stable(rot_q));
endmodule

// File: tb/quad_decoder_tb_top.sv
module quad_decoder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_div = '0;
   logic [10:0] cfg_dbn_time = '0;
   logic        ctl_we = 1'b0, ctl_enable = 1'b0, ctl_pos_clr = 1'b0, ctl_rot_clr = 1'b0;
   logic        ctl_rot_mode = 1'b0, ctl_full_clr = 1'b0, ctl_dbn_en = 1'b0;
   logic [3:0]  ctl_irq_mask = '0;
   logic        sts_clr_we = 1'b0;
   logic [3:0]  sts_clr_mask = '0;
   logic        in_a = 1'b0, in_b = 1'b0, in_idx = 1'b0;
   logic [15:0] pos_count, rot_count;
   logic [3:0]  status;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   quad_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
      .cfg_dbn_time(cfg_dbn_time), .ctl_we(ctl_we), .ctl_enable(ctl_enable),
      .ctl_pos_clr(ctl_pos_clr), .ctl_rot_clr(ctl_rot_clr), .ctl_rot_mode(ctl_rot_mode),
      .ctl_full_clr(ctl_full_clr), .ctl_dbn_en(ctl_dbn_en), .ctl_irq_mask(ctl_irq_mask),
      .sts_clr_we(sts_clr_we), .sts_clr_mask(sts_clr_mask), .in_a(in_a), .in_b(in_b),
      .in_idx(in_idx), .pos_count(pos_count), .rot_count(rot_count), .status(status),
      .irq(irq)
   );

   // {a, b, idx, expected position, expected rotation}
   localparam int NV = 13;
   localparam logic [34:0] VEC [NV] = '{
      {3'b010, 16'd1,      16'd0},
      {3'b110, 16'd2,      16'd0},
      {3'b100, 16'd3,      16'd0},
      {3'b001, 16'd4,      16'd1},
      {3'b000, 16'd4,      16'd1},
      {3'b100, 16'd3,      16'd1},
      {3'b101, 16'd3,      16'd0},
      {3'b100, 16'd3,      16'd0},
      {3'b110, 16'd2,      16'd0},
      {3'b010, 16'd1,      16'd0},
      {3'b000, 16'd0,      16'd0},
      {3'b100, 16'hFFFF,   16'd0},
      {3'b000, 16'd0,      16'd0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ctl(input logic en, input logic pclr, input logic rclr, input logic mode,
                      input logic fclr, input logic dben, input logic [3:0] mask);
      @(negedge clk);
      ctl_enable = en; ctl_pos_clr = pclr; ctl_rot_clr = rclr; ctl_rot_mode = mode;
      ctl_full_clr = fclr; ctl_dbn_en = dben; ctl_irq_mask = mask; ctl_we = 1'b1;
      @(negedge clk);
      ctl_we = 1'b0; ctl_pos_clr = 1'b0; ctl_rot_clr = 1'b0; ctl_full_clr = 1'b0;
   endtask

   task automatic cfg(input logic [4:0] dv, input logic [10:0] tm);
      @(negedge clk);
      cfg_div = dv; cfg_dbn_time = tm; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_ab(input logic a, input logic b);
      @(negedge clk);
      in_a = a; in_b = b;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(2);
      // R1 reset state
      chk("R1 pos", 32'(pos_count), 0);
      chk("R1 rot", 32'(rot_count), 0);
      chk("R1 status", 32'(status), 0);
      chk("R1 irq", 32'(irq), 0);

      ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF);

      // R2 R4 R5 vector walk, debounce off, tick every cycle
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         in_a = VEC[v][34]; in_b = VEC[v][33]; in_idx = VEC[v][32];
         wait_cyc(8);
         chk($sformatf("R2/R4 pos vec %0d", v), 32'(pos_count), 32'(VEC[v][31:16]));
         chk($sformatf("R5 rot vec %0d", v), 32'(rot_count), 32'(VEC[v][15:0]));
      end
      chk("R4 R5 flags after walk", 32'(status), 32'h7);
      chk("R13 irq all masked in", 32'(irq), 1);

      // R3 illegal: 00 to 11
      set_ab(1'b1, 1'b1);
      wait_cyc(8);
      chk("R3 pos unchanged", 32'(pos_count), 0);
      chk("R3 err flag", 32'(status), 32'hF);

      // R13 write-1-clear of bit 3, then mask off
      @(negedge clk);
      sts_clr_mask = 4'b1000; sts_clr_we = 1'b1;
      @(negedge clk);
      sts_clr_we = 1'b0;
      wait_cyc(1);
      chk("R13 w1c", 32'(status), 32'h7);
      ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0);
      wait_cyc(1);
      chk("R13 irq masked", 32'(irq), 0);
      chk("R13 status kept", 32'(status), 32'h7);

      // 11 -> 10 up to position 1
      set_ab(1'b1, 1'b0);
      wait_cyc(8);
      chk("R2 up step", 32'(pos_count), 1);

      // R8 R10 clears ignored while enabled
      ctl(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0);
      wait_cyc(2);
      chk("R8 clear blocked when enabled", 32'(pos_count), 1);
      ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0);
      wait_cyc(2);
      chk("R10 full clear blocked when enabled", 32'(pos_count), 1);

      // R7 disable clears flags and freezes counting
      ctl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF);
      wait_cyc(2);
      chk("R7 flags cleared", 32'(status), 0);
      set_ab(1'b0, 1'b0);
      wait_cyc(8);
      chk("R7 no count when disabled", 32'(pos_count), 1);

      // R8 clear honoured when disabled
      ctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF);
      wait_cyc(2);
      chk("R8 clear when disabled", 32'(pos_count), 0);

      // R6 wrap counting mode
      ctl(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'hF);
      set_ab(1'b1, 1'b0);
      wait_cyc(8);
      chk("R6 pos underflow", 32'(pos_count), 32'hFFFF);
      chk("R6 rot minus one", 32'(rot_count), 32'hFFFF);
      @(negedge clk); in_idx = 1'b1;
      wait_cyc(8);
      @(negedge clk); in_idx = 1'b0;
      wait_cyc(8);
      chk("R6 index ignored in mode 1", 32'(rot_count), 32'hFFFF);

      // R9 rotation clear gating
      ctl(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'hF);
      wait_cyc(2);
      chk("R9 rot clear blocked", 32'(rot_count), 32'hFFFF);
      ctl(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'hF);
      ctl(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'hF);
      wait_cyc(2);
      chk("R9 rot cleared", 32'(rot_count), 0);
      chk("R9 pos untouched", 32'(pos_count), 32'hFFFF);

      // R6 overflow adds one, then R10 full clear
      ctl(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'hF);
      set_ab(1'b0, 1'b0);
      wait_cyc(8);
      chk("R6 rot plus one on overflow", 32'(rot_count), 1);
      set_ab(1'b0, 1'b1);
      wait_cyc(8);
      chk("R2 pos one", 32'(pos_count), 1);
      ctl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF);
      ctl(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'hF);
      wait_cyc(2);
      chk("R10 full clear pos", 32'(pos_count), 0);
      chk("R10 full clear rot", 32'(rot_count), 0);
      chk("R10 full clear status", 32'(status), 0);

      // R12 debounce at divider 0, time 6
      cfg(5'd0, 11'd6);
      ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF);
      set_ab(1'b1, 1'b1);
      wait_cyc(3);
      in_a = 1'b0;
      wait_cyc(20);
      chk("R12 short glitch dropped", 32'(pos_count), 0);
      set_ab(1'b1, 1'b1);
      wait_cyc(20);
      chk("R12 held level accepted", 32'(pos_count), 1);

      // R11 divider 9 stretches the debounce window to ticks of 10 cycles
      cfg(5'd9, 11'd3);
      set_ab(1'b1, 1'b0);
      wait_cyc(15);
      in_b = 1'b1;
      wait_cyc(60);
      chk("R11 15-cycle glitch below three ticks", 32'(pos_count), 1);
      set_ab(1'b1, 1'b0);
      wait_cyc(80);
      chk("R11 long hold accepted", 32'(pos_count), 2);
      chk("R12 no illegal flag", 32'(status[3]), 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule